// File: doc/BRIEF.md
# Power-Managed Wake Event Generator

This block follows the power state of one bus function in a serial-bus host controller and decides when that function raises a wake request. While the function is in either full-power state, any interrupt source that is pending and unmasked sets a sticky wake status bit. While the function sits in one of the three low-power states, a card-insertion pulse sets the same bit, but only when wake signalling is enabled. The wake request pin is open-drain. The block drives an active-low output enable for that pad, and the enable is low for as long as both the status bit and the wake enable are set.

A configuration bit decides how interrupt sources are qualified for wake. When the bit is clear, a source counts only if the master interrupt enable is also on. When the bit is set, the master enable is ignored. The value of this bit is mirrored to a read-back output that feeds an identification register. A small write port reaches two registers: the power-management control/status word and the miscellaneous configuration word.

Top module: `pme_wake_top`

## Requirements
- R1: After reset the state code is 0 (D0 uninitialized), the wake status is 0, the pad enable `pmeOeN` is 1 and `idIgnMstr` is 0.
- R2: A write to address 0 loads the state from data bits [1:0]. The value 0 gives state code 1 (D0 active), 1 gives code 2 (D1), 2 gives code 3 (D2) and 3 gives code 4 (D3). Without a write to address 0 the state holds.
- R3: In state codes 0 and 1 with configuration bit 10 clear, the status sets on the edge after some source n has event[n]=1, mask[n]=1 and masterIntEn=1. A source with the master enable at 0, or with its event and mask bits on different positions, does not set it.
- R4: In state codes 0 and 1 with configuration bit 10 set, event[n]=1 and mask[n]=1 set the status whatever the value of masterIntEn.
- R5: Writing address 1 stores data bit 10 as the ignore-master bit. `idIgnMstr` shows that bit from the next cycle on.
- R6: In state codes 2 to 4, a cardInsert pulse sets the status only if the wake enable (bit 8 of the address-0 write) is 1. In state codes 0 and 1 the pulse has no effect.
- R7: In state codes 2 to 4, interrupt events do not set the status.
- R8: A write to address 0 with data bit 15 at 1 clears the status, and a 0 in that bit leaves it unchanged. When a set condition occurs in the same cycle as a clear, the set wins.
- R9: `pmeOeN` is 0 exactly when the status and the wake enable are both 1, and 1 otherwise.
- R10: The source count is the parameter NUM_SRC (default 32), and the highest source takes part in qualification like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intEvent | input | NUM_SRC | Pending interrupt events |
| intMask | input | NUM_SRC | Per-source interrupt masks |
| masterIntEn | input | 1 | Master interrupt enable |
| cardInsert | input | 1 | Card-insertion pulse |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the control/status word, 1 selects the configuration word |
| regWData | input | 16 | Write data |
| pwrState | output | 3 | Power state code |
| pmeSts | output | 1 | Wake status bit |
| pmeOeN | output | 1 | Active-low output enable of the open-drain wake pad |
| idIgnMstr | output | 1 | Mirror of the ignore-master bit for the identification register |

## Verification
On every cycle the checker confirms four things: the pad enable is never low without the status bit, a new status can always be traced to a qualifying event or card pulse in the previous cycle, the state moves only on a control write, and the mirror bit follows the configuration write. It also confirms that an event with the master enable on sets the status, and that a clear with no set source drops it. Some behaviours can only be shown by the bench's scenarios, because they depend on a chosen sequence of writes and stimulus: the effect of the ignore-master bit with the master enable off, card pulses that are blocked by the enable or by the full-power state, interrupts that are ignored in low power, set winning over clear, and the highest source bit.

// File: rtl/pme_wake_pkg.sv
package pme_wake_pkg;

  typedef enum logic [2:0] {
    PS_D0_UNINIT = 3'd0,
    PS_D0_ACTIVE = 3'd1,
    PS_D1        = 3'd2,
    PS_D2        = 3'd3,
    PS_D3        = 3'd4
  } pwrState_e;

  localparam int REG_W        = 16;
  localparam int STATE_LSB    = 0;
  localparam int WAKE_EN_BIT  = 8;
  localparam int IGN_MSTR_BIT = 10;
  localparam int STS_BIT      = 15;

  typedef struct packed {
    logic clrSts;
    logic fullPower;
    logic armCard;
    logic ignoreMaster;
    logic wakeEnable;
  } ctlStrobe_t;

endpackage

// File: rtl/pme_wake_ctl.sv
module pme_wake_ctl
  import pme_wake_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWData,
  output pwrState_e        curState,
  output ctlStrobe_t       strobe
);

  logic wakeEn;
  logic ignMstr;

  function automatic pwrState_e decodeField(input logic [1:0] field);
    case (field)
      2'd0:    decodeField = PS_D0_ACTIVE;
      2'd1:    decodeField = PS_D1;
      2'd2:    decodeField = PS_D2;
      default: decodeField = PS_D3;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= PS_D0_UNINIT;
      wakeEn   <= 1'b0;
      ignMstr  <= 1'b0;
    end else if (regWr) begin
      if (!regAddr) begin
        curState <= decodeField(regWData[STATE_LSB +: 2]);
        wakeEn   <= regWData[WAKE_EN_BIT];
      end else begin
        ignMstr  <= regWData[IGN_MSTR_BIT];
      end
    end
  end

  always_comb begin
    strobe.clrSts       = regWr && !regAddr && regWData[STS_BIT];
    strobe.fullPower    = (curState == PS_D0_UNINIT) || (curState == PS_D0_ACTIVE);
    strobe.armCard      = !strobe.fullPower && wakeEn;
    strobe.ignoreMaster = ignMstr;
    strobe.wakeEnable   = wakeEn;
  end

endmodule

// File: rtl/pme_wake_dp.sv
module pme_wake_dp
  import pme_wake_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] intEvent,
  input  logic [NUM_SRC-1:0] intMask,
  input  logic               masterIntEn,
  input  logic               cardInsert,
  input  ctlStrobe_t         strobe,
  output logic               pmeSts,
  output logic               pmeOeN
);

  logic [NUM_SRC-1:0] srcLive;
  logic               gateOpen;
  logic               anyLive;
  logic               setSts;

  assign gateOpen = strobe.ignoreMaster || masterIntEn;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign srcLive[n] = intEvent[n] && intMask[n] && gateOpen;
  end

  assign anyLive = |srcLive;
  assign setSts  = (strobe.fullPower && anyLive) || (strobe.armCard && cardInsert);

  always_ff @(posedge clk) begin
    if (!rstN)              pmeSts <= 1'b0;
    else if (setSts)        pmeSts <= 1'b1;
    else if (strobe.clrSts) pmeSts <= 1'b0;
  end

  assign pmeOeN = !(pmeSts && strobe.wakeEnable);

endmodule

// File: rtl/pme_wake_top.sv
module pme_wake_top
  import pme_wake_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] intEvent,
  input  logic [NUM_SRC-1:0] intMask,
  input  logic               masterIntEn,
  input  logic               cardInsert,
  input  logic               regWr,
  input  logic               regAddr,
  input  logic [15:0]        regWData,
  output logic [2:0]         pwrState,
  output logic               pmeSts,
  output logic               pmeOeN,
  output logic               idIgnMstr
);

  pwrState_e  curState;
  ctlStrobe_t strobe;

  pme_wake_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWData (regWData),
    .curState (curState),
    .strobe   (strobe)
  );

  pme_wake_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .intEvent    (intEvent),
    .intMask     (intMask),
    .masterIntEn (masterIntEn),
    .cardInsert  (cardInsert),
    .strobe      (strobe),
    .pmeSts      (pmeSts),
    .pmeOeN      (pmeOeN)
  );

  assign pwrState  = curState;
  assign idIgnMstr = strobe.ignoreMaster;

endmodule

// File: rtl/pme_wake_chk.sv
module pme_wake_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] intEvent,
  input logic [NUM_SRC-1:0] intMask,
  input logic               masterIntEn,
  input logic               cardInsert,
  input logic               regWr,
  input logic               regAddr,
  input logic [15:0]        regWData,
  input logic [2:0]         pwrState,
  input logic               pmeSts,
  input logic               pmeOeN,
  input logic               idIgnMstr
);

  // R9
  oe_needs_sts_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pmeOeN |-> pmeSts);

  // R3
  event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrState <= 3'd1) && (|(intEvent & intMask)) && masterIntEn) |=> pmeSts);

  // R7
  rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pmeSts) |-> $past(((pwrState <= 3'd1) && (|(intEvent & intMask))) ||
                            ((pwrState >= 3'd2) && cardInsert)));

  // R2
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && !regAddr) |=> $stable(pwrState));

  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrState <= 3'd4);

  // R5
  id_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr) |=> (idIgnMstr == $past(regWData[10])));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regAddr && regWData[15] && !(|(intEvent & intMask)) && !cardInsert)
      |=> !pmeSts);

endmodule

bind pme_wake_top pme_wake_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/test_pme_wake_top.sv
module test_pme_wake_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] intEvent = '0;
  logic [NSRC-1:0] intMask = '0;
  logic            masterIntEn = 1'b0;
  logic            cardInsert = 1'b0;
  logic            regWr = 1'b0;
  logic            regAddr = 1'b0;
  logic [15:0]     regWData = '0;
  logic [2:0]      pwrState;
  logic            pmeSts, pmeOeN, idIgnMstr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pme_wake_top #(.NUM_SRC(NSRC)) i_pme_wake_top (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWr = 1'b0; regWData = '0;
  endtask

  task automatic pulseCard();
    @(negedge clk); cardInsert = 1'b1;
    @(negedge clk); cardInsert = 1'b0;
  endtask

  task automatic applyEvent(input logic [NSRC-1:0] ev, input logic [NSRC-1:0] mk, input logic m);
    @(negedge clk); intEvent = ev; intMask = mk; masterIntEn = m;
    @(negedge clk); intEvent = '0; intMask = '0; masterIntEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 state", pwrState, 0);
    check("R1 sts", pmeSts, 0);
    check("R1 oeN", pmeOeN, 1);
    check("R1 id", idIgnMstr, 0);
  endtask

  task automatic t_states();
    wrReg(1'b0, 16'h0001); check("R2 D1", pwrState, 2);
    wrReg(1'b0, 16'h0002); check("R2 D2", pwrState, 3);
    wrReg(1'b0, 16'h0003); check("R2 D3", pwrState, 4);
    @(negedge clk);        check("R2 hold", pwrState, 4);
    wrReg(1'b1, 16'h0000); check("R2 other addr", pwrState, 4);
    wrReg(1'b0, 16'h0000); check("R2 D0 active", pwrState, 1);
  endtask

  task automatic t_masterRule();
    applyEvent(32'h20, 32'h20, 1'b0); check("R3 master off", pmeSts, 0);
    applyEvent(32'h08, 32'h10, 1'b1); check("R3 misaligned", pmeSts, 0);
    applyEvent(32'h20, 32'h20, 1'b1); check("R3 qualified", pmeSts, 1);
    wrReg(1'b0, 16'h0000);            check("R8 zero keeps", pmeSts, 1);
    wrReg(1'b0, 16'h8000);            check("R8 w1c", pmeSts, 0);
  endtask

  task automatic t_ignore();
    wrReg(1'b1, 16'h0400);            check("R5 id set", idIgnMstr, 1);
    applyEvent(32'h02, 32'h02, 1'b0); check("R4 master ignored", pmeSts, 1);
    wrReg(1'b0, 16'h8000);            check("R8 clear", pmeSts, 0);
    wrReg(1'b1, 16'h0000);            check("R5 id clear", idIgnMstr, 0);
    applyEvent(32'h02, 32'h02, 1'b0); check("R3 rule restored", pmeSts, 0);
  endtask

  task automatic t_card();
    wrReg(1'b0, 16'h0003);            // D3, wake disabled
    pulseCard();                      check("R6 disabled", pmeSts, 0);
    check("R9 idle oe", pmeOeN, 1);
    wrReg(1'b0, 16'h0103);            // D3, wake enabled
    pulseCard();                      check("R6 card sets", pmeSts, 1);
    check("R9 oe low", pmeOeN, 0);
    wrReg(1'b0, 16'h0003);            check("R9 enable off", pmeOeN, 1);
    wrReg(1'b0, 16'h8102);            check("R8 clear in D2", pmeSts, 0);
    applyEvent(32'h01, 32'h01, 1'b1); check("R7 low power event", pmeSts, 0);
    wrReg(1'b0, 16'h0100);            // D0 active, wake enabled
    pulseCard();                      check("R6 card in D0", pmeSts, 0);
  endtask

  task automatic t_setWins();
    @(negedge clk);
    intEvent = 32'h8000_0000; intMask = 32'h8000_0000; masterIntEn = 1'b1;
    @(negedge clk);                   check("R10 top source", pmeSts, 1);
    regWr = 1'b1; regAddr = 1'b0; regWData = 16'h8100;
    @(negedge clk);
    regWr = 1'b0; regWData = '0;      check("R8 set wins", pmeSts, 1);
    intEvent = '0; intMask = '0; masterIntEn = 1'b0;
    wrReg(1'b0, 16'h8100);            check("R8 cleared", pmeSts, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_states();
    t_masterRule();
    t_ignore();
    t_card();
    t_setWins();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule